// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Line Cache

This block lets a processor read a serial flash as if it were ordinary memory. It holds one 1024-byte line of flash contents in a local buffer. Reads whose 32-bit word lies completely inside that line are answered in the same cycle. Any other read stalls the requester while the block refills the line.

A refill is one framed exchange over a byte-wide request/acknowledge link to a downstream serial shifter. The block first sends a command header built from a configuration word. The header is an instruction byte, a three-byte flash address, an optional mode byte and a programmable run of zero dummy bytes. The block discards whatever comes back during the header. It then clocks out 1024 zero bytes, grouped in rounds of 64, and stores each returned byte at the next buffer position. When the line is full, the stalled read is answered.

The flash address is the line-aligned request address, halved when the configuration selects two parallel flash buses. During the fill, bit 24 of that flash address drives an upper-page select output. Outside a fill, that output follows a configuration bit.

Top module: `flash_line_cache`

## Requirements
- R1: After reset the configuration word is 0x03A002EB and the line is invalid. At reset, `xfer_req`, `xfer_sel`, `rd_ready` and `upper_page` are all low, and the first read always starts a fill.
- R2: A read hits when the line is valid, the address bits above bit 9 match the cached line, and the offset (address bits 9..0) is at most 1020. A hit raises `rd_ready` in the same cycle as `rd_valid` with no transfer. Any other read starts a fill.
- R3: A fill fetches the line aligned down to 1024 bytes. The flash address sent is that aligned address, or half of it when configuration bit 30 is set (two-bus mode).
- R4: The header is sent in this order. First the instruction byte, configuration bits 7..0. Then flash address bits 23..16, 15..8 and 7..0. Then the mode byte, configuration bits 23..16, but only when configuration bit 25 is 1. Last come N zero bytes, where N is configuration bits 10..8.
- R5: After the header exactly 1024 bytes of value 0x00 are sent. The k-th returned byte is stored at buffer offset k. `xfer_last` is high on the final header byte and on every 64th data byte.
- R6: Bytes returned during the header never reach the buffer.
- R7: `rd_data` bits 8k+7..8k hold the buffered byte at offset (address bits 9..0) + k, for k = 0..3.
- R8: A read at offset 1021, 1022 or 1023 always refills its own line. Its bytes then wrap within the line, so offset 1024 reads as offset 0.
- R9: While `xfer_sel` is high, `upper_page` equals flash address bit 24 of the line being fetched. Otherwise it equals configuration bit 28.
- R10: A configuration write invalidates the line. A write during a fill still lets the pending read complete, but leaves the line invalid afterwards.
- R11: A missing read sees `rd_ready` low until the whole line has been stored. `rd_ready` is never high without `rd_valid`.
- R12: `xfer_req` stays high with `xfer_tx` stable until `xfer_ack`. `xfer_sel` is high for the whole fill and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| rd_valid | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_ready | output | 1 | Read accepted, `rd_data` valid this cycle |
| rd_data | output | 32 | Little-endian read data |
| xfer_sel | output | 1 | Flash frame active (chip select) |
| xfer_req | output | 1 | Byte transfer request |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_last | output | 1 | Last byte of header or of a 64-byte round |
| xfer_ack | input | 1 | Byte transfer done, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte shifted in |
| upper_page | output | 1 | Upper flash page select |

## Verification
The hardest case to reach is a configuration write that lands in the middle of a fill. The read must still be answered, yet the line must stay invalid. The bench forks a missing read and a delayed configuration write, so the write lands a few hundred byte transfers into the data phase. It then reads the same address and expects a second fill. The three wrap-around offsets are also awkward, because they miss against the very line just fetched. The bench targets them directly after a fill and checks both the refill and the wrapped byte order. The bench then sweeps every dummy count, with the mode byte on and off, in both bus modes. Acknowledge gaps are switched in and out, and every header and round marker is compared with a header the bench builds itself.

// File: rtl/flc_pkg.sv
package flc_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_CMD  = 2'd1,
    FS_DATA = 2'd2,
    FS_RESP = 2'd3
  } fill_state_e;

  localparam logic [31:0] CFG_RESET = 32'h03A0_02EB;

  // configuration field positions
  localparam int INSTR_LSB     = 0;
  localparam int DUMMY_LSB     = 8;
  localparam int MODE_LSB      = 16;
  localparam int MODE_EN_BIT   = 25;
  localparam int IDLE_PAGE_BIT = 28;
  localparam int DUAL_BIT      = 30;

  // header length: instruction + 3 address bytes + optional mode + dummies
  function automatic logic [3:0] cmd_len(input logic [31:0] cfg);
    return 4'd4 + {3'd0, cfg[MODE_EN_BIT]} + {1'b0, cfg[DUMMY_LSB +: 3]};
  endfunction

  // byte number idx of the command header
  function automatic logic [7:0] cmd_byte(input logic [3:0] idx,
                                          input logic [31:0] cfg,
                                          input logic [31:0] fa);
    logic [7:0] b;
    case (idx)
      4'd0:    b = cfg[INSTR_LSB +: 8];
      4'd1:    b = fa[23:16];
      4'd2:    b = fa[15:8];
      4'd3:    b = fa[7:0];
      4'd4:    b = cfg[MODE_EN_BIT] ? cfg[MODE_LSB +: 8] : 8'h00;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic [31:0] align_down(input logic [31:0] a,
                                             input int unsigned line_bytes);
    return a & ~(32'(line_bytes) - 32'd1);
  endfunction

  function automatic logic [31:0] flash_addr_of(input logic [31:0] aligned,
                                                input logic dual);
    return dual ? (aligned >> 1) : aligned;
  endfunction

endpackage

// File: rtl/flc_tag.sv
module flc_tag
  import flc_pkg::*;
#(
  parameter int ADDR_W     = 25,
  parameter int LINE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              fill_start,
  input  logic              fill_done,
  output logic [31:0]       cfg_q,
  output logic              line_hit,
  output logic              line_valid
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_WORD_OFF = OFF_W'(LINE_BYTES - 4);

  logic [31:0]      cfg_r;
  logic [TAG_W-1:0] tag_r;
  logic             valid_r;
  logic             dirty_r;   // configuration changed since fill start

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r   <= CFG_RESET;
      tag_r   <= '0;
      valid_r <= 1'b0;
      dirty_r <= 1'b0;
    end else begin
      if (cfg_wr) cfg_r <= cfg_wdata;
      if (fill_start) begin
        tag_r   <= rd_addr[ADDR_W-1:OFF_W];
        dirty_r <= 1'b0;
      end
      if (cfg_wr) dirty_r <= 1'b1;
      if (cfg_wr || fill_start)  valid_r <= 1'b0;
      else if (fill_done)        valid_r <= !dirty_r;
    end
  end

  assign cfg_q      = cfg_r;
  assign line_valid = valid_r;
  assign line_hit   = valid_r && (tag_r == rd_addr[ADDR_W-1:OFF_W])
                      && (rd_addr[OFF_W-1:0] <= LAST_WORD_OFF);

  AST_CFG_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !line_valid);  // R10

endmodule

// File: rtl/flc_line_buf.sv
module flc_line_buf #(
  parameter int LINE_BYTES = 1024,
  parameter int LANES      = 4
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [$clog2(LINE_BYTES)-1:0] waddr,
  input  logic [7:0]                    wdata,
  input  logic [$clog2(LINE_BYTES)-1:0] roff,
  output logic [8*LANES-1:0]            rdata
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [7:0] mem [LINE_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // each lane reads offset + lane, wrapping inside the line
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [OFF_W-1:0] lane_off;
    assign lane_off          = roff + OFF_W'(g);
    assign rdata[8*g +: 8]   = mem[lane_off];
  end

endmodule

// File: rtl/flc_fill_seq.sv
module flc_fill_seq
  import flc_pkg::*;
#(
  parameter int ADDR_W      = 25,
  parameter int LINE_BYTES  = 1024,
  parameter int ROUND_BYTES = 64,
  parameter int PAGE_BIT    = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_valid,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic                          line_hit,
  input  logic [31:0]                   cfg,
  output logic                          rd_ready,
  output logic                          fill_start,
  output logic                          fill_done,
  output logic                          xfer_sel,
  output logic                          xfer_req,
  output logic [7:0]                    xfer_tx,
  output logic                          xfer_last,
  input  logic                          xfer_ack,
  output logic                          upper_page,
  output logic                          buf_we,
  output logic [$clog2(LINE_BYTES)-1:0] buf_waddr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int RND_W = $clog2(ROUND_BYTES);
  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(LINE_BYTES - 1);

  fill_state_e      state;
  logic [3:0]       cnt;
  logic [3:0]       hlen_l;
  logic [OFF_W-1:0] dcnt;
  logic [31:0]      fa_r;
  logic [31:0]      cfg_l;
  logic [31:0]      fa_next;
  logic             cmd_last;
  logic             data_last;
  logic             in_cmd;
  logic             in_data;

  assign fa_next   = flash_addr_of(align_down(32'(rd_addr), LINE_BYTES), cfg[DUAL_BIT]);
  assign in_cmd    = (state == FS_CMD);
  assign in_data   = (state == FS_DATA);
  assign cmd_last  = (cnt == 4'(hlen_l - 4'd1));
  assign data_last = (dcnt == LAST_IDX);

  assign fill_start = (state == FS_IDLE) && rd_valid && !line_hit;
  assign fill_done  = in_data && xfer_ack && data_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      cnt    <= '0;
      hlen_l <= 4'd4;
      dcnt   <= '0;
      fa_r   <= '0;
      cfg_l  <= CFG_RESET;
    end else begin
      case (state)
        FS_IDLE: if (fill_start) begin
          state  <= FS_CMD;
          cnt    <= '0;
          fa_r   <= fa_next;
          cfg_l  <= cfg;
          hlen_l <= cmd_len(cfg);
        end
        FS_CMD: if (xfer_ack) begin
          if (cmd_last) begin
            state <= FS_DATA;
            dcnt  <= '0;
          end else begin
            cnt <= cnt + 4'd1;
          end
        end
        FS_DATA: if (xfer_ack) begin
          dcnt <= dcnt + 1'b1;
          if (data_last) state <= FS_RESP;
        end
        FS_RESP: if (rd_valid) state <= FS_IDLE;
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign xfer_sel   = in_cmd || in_data;
  assign xfer_req   = in_cmd || in_data;
  assign xfer_tx    = in_cmd ? cmd_byte(cnt, cfg_l, fa_r) : 8'h00;
  assign xfer_last  = (in_cmd && cmd_last) || (in_data && (&dcnt[RND_W-1:0]));
  assign upper_page = xfer_sel ? fa_r[PAGE_BIT] : cfg[IDLE_PAGE_BIT];
  assign buf_we     = in_data && xfer_ack;
  assign buf_waddr  = dcnt;
  assign rd_ready   = rd_valid && (((state == FS_IDLE) && line_hit) || (state == FS_RESP));

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));  // R12
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> rd_valid);  // R11
  AST_NO_READY_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_sel |-> !rd_ready);  // R11

endmodule

// File: rtl/flash_line_cache.sv
module flash_line_cache
  import flc_pkg::*;
#(
  parameter int ADDR_W      = 25,
  parameter int LINE_BYTES  = 1024,
  parameter int ROUND_BYTES = 64,
  parameter int PAGE_BIT    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic [31:0]       rd_data,
  output logic              xfer_sel,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  output logic              xfer_last,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              upper_page
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [31:0]      cfg_q;
  logic             line_hit;
  logic             line_valid;
  logic             fill_start;
  logic             fill_done;
  logic             buf_we;
  logic [OFF_W-1:0] buf_waddr;

  flc_tag #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_tag (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .fill_start(fill_start), .fill_done(fill_done),
    .cfg_q(cfg_q), .line_hit(line_hit), .line_valid(line_valid)
  );

  flc_fill_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
                 .ROUND_BYTES(ROUND_BYTES), .PAGE_BIT(PAGE_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .line_hit(line_hit), .cfg(cfg_q), .rd_ready(rd_ready),
    .fill_start(fill_start), .fill_done(fill_done), .xfer_sel(xfer_sel),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_last(xfer_last),
    .xfer_ack(xfer_ack), .upper_page(upper_page), .buf_we(buf_we),
    .buf_waddr(buf_waddr)
  );

  flc_line_buf #(.LINE_BYTES(LINE_BYTES), .LANES(4)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(xfer_rx),
    .roff(rd_addr[OFF_W-1:0]), .rdata(rd_data)
  );

  AST_STORE_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (xfer_ack && xfer_req && xfer_tx == 8'h00));  // R6
  AST_MISS_STARTS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !line_hit && !xfer_sel && !rd_ready) |=> xfer_sel);  // R2
  AST_PAGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_sel |-> (upper_page == cfg_q[IDLE_PAGE_BIT]));  // R9
  AST_VALID_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_sel |-> !line_valid);  // R10

endmodule

// File: tb/sim_flash_line_cache.sv
module sim_flash_line_cache;
  localparam int AW   = 25;
  localparam int LINE = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_ready;
  logic [31:0]   rd_data;
  logic          xfer_sel, xfer_req, xfer_last, upper_page;
  logic [7:0]    xfer_tx;
  logic          xfer_ack = 1'b0;
  logic [7:0]    xfer_rx = 8'h00;

  flash_line_cache u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .xfer_sel(xfer_sel), .xfer_req(xfer_req),
    .xfer_tx(xfer_tx), .xfer_last(xfer_last), .xfer_ack(xfer_ack),
    .xfer_rx(xfer_rx), .upper_page(upper_page)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] cfg_sh = 32'h03A0_02EB;
  logic [31:0] exp_fa = '0;
  bit          stall_en = 0;
  logic [7:0]  flog [0:1199];
  int          fidx = 0;
  int          fills = 0;
  int          mark_err = 0, page_err = 0, dtx_err = 0;
  bit          sel_prev = 0;
  int          cyc = 0;
  int          hl_m;
  bit          exp_last;

  function automatic logic [7:0] fb(input logic [31:0] a);
    logic [31:0] t;
    t = (a * 32'd37) ^ (a >> 9) ^ ((a >> 17) * 32'd11);
    return t[7:0] ^ t[15:8];
  endfunction

  function automatic int hlen_b(input logic [31:0] c);
    return 4 + int'(c[25]) + int'(c[10:8]);
  endfunction

  function automatic logic [31:0] fa_of(input logic [31:0] a, input logic [31:0] c);
    logic [31:0] al;
    al = a & ~32'(LINE - 1);
    return c[30] ? (al >> 1) : al;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model and monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (xfer_sel && !sel_prev) begin
      fidx = 0;
      fills++;
    end
    sel_prev = xfer_sel;
    if (xfer_req && (!stall_en || (cyc % 4) != 2)) begin
      hl_m = hlen_b(cfg_sh);
      if (fidx < 1200) flog[fidx] = xfer_tx;
      exp_last = (fidx == hl_m - 1) || (fidx >= hl_m && ((fidx - hl_m) % 64) == 63);
      if (xfer_last !== exp_last) mark_err++;
      if (upper_page !== exp_fa[24]) page_err++;
      if (fidx >= hl_m && xfer_tx != 8'h00) dtx_err++;
      if (fidx < hl_m) xfer_rx <= 8'hC3 ^ 8'(fidx);
      else             xfer_rx <= fb(exp_fa + 32'(fidx - hl_m));
      xfer_ack <= 1'b1;
      fidx++;
    end else begin
      xfer_ack <= 1'b0;
      xfer_rx  <= 8'h5A;
    end
  end

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    cfg_sh = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic check_frame(input string req);
    int hl;
    logic [7:0] e;
    bit ok;
    hl = hlen_b(cfg_sh);
    ok = 1;
    for (int i = 0; i < hl; i++) begin
      case (i)
        0: e = cfg_sh[7:0];
        1: e = exp_fa[23:16];
        2: e = exp_fa[15:8];
        3: e = exp_fa[7:0];
        4: e = cfg_sh[25] ? cfg_sh[23:16] : 8'h00;
        default: e = 8'h00;
      endcase
      if (flog[i] !== e) begin
        ok = 0;
        chk(0, req, $sformatf("header byte %0d", i), flog[i], e);
      end
    end
    if (ok) chk(1, req, "header", 0, 0);
    chk(fidx == hl + LINE, "R5", "frame length", fidx, hl + LINE);
    chk(mark_err == 0, "R5", "round markers", mark_err, 0);
    chk(dtx_err == 0, "R5", "data bytes zero", dtx_err, 0);
    chk(page_err == 0, "R9", "page during fill", page_err, 0);
  endtask

  task automatic do_read(input logic [31:0] a, input bit exp_fill, input string req);
    int f0, cycles;
    logic [31:0] exp_d;
    logic [31:0] fa;
    int off;
    fa = fa_of(a, cfg_sh);
    if (exp_fill) exp_fa = fa;
    mark_err = 0; page_err = 0; dtx_err = 0;
    f0 = fills;
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr = AW'(a);
    #1;
    cycles = 0;
    while (!rd_ready && cycles < 5000) begin
      @(negedge clk);
      #1;
      cycles++;
    end
    off = int'(a % LINE);
    for (int k = 0; k < 4; k++)
      exp_d[8*k +: 8] = fb(fa + 32'((off + k) % LINE));
    chk((fills != f0) == exp_fill, req, "fill started", fills - f0, exp_fill);
    chk(rd_data === exp_d, exp_fill ? "R7" : req, "read data", rd_data, exp_d);
    if (exp_fill) chk(cycles >= LINE, "R11", "stall length", cycles, LINE);
    else          chk(cycles == 0, "R2", "hit latency", cycles, 0);
    @(posedge clk);
    #1;
    rd_valid = 1'b0;
    if (exp_fill) check_frame(req);
    #1;
    chk(xfer_sel == 1'b0, "R12", "select idle", xfer_sel, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R11: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    chk(xfer_req == 1'b0, "R1", "xfer_req at reset", xfer_req, 0);
    chk(xfer_sel == 1'b0, "R1", "xfer_sel at reset", xfer_sel, 0);
    chk(rd_ready == 1'b0, "R1", "rd_ready at reset", rd_ready, 0);
    chk(upper_page == 1'b0, "R1", "upper_page at reset", upper_page, 0);

    // R1/R4: first read misses, default header EB 00 00 00 A0 00 00
    do_read(32'h100, 1, "R1");
    // R2/R7: hit sweep over the whole valid window
    for (int o = 0; o <= 1020; o += 3) do_read(32'(o), 0, "R2");
    do_read(32'd1020, 0, "R2");
    // R8: wrap offsets refill the same line
    do_read(32'd1021, 1, "R8");
    do_read(32'd1023, 1, "R8");
    do_read(32'd1022, 1, "R8");
    // R2: neighbouring lines miss
    do_read(32'h400, 1, "R2");
    do_read(32'h3FC, 1, "R3");

    // R10/R9: config write invalidates; idle page follows bit 28
    cfg_write(32'h1000_000B);
    #1;
    chk(upper_page == 1'b1, "R9", "idle page from config", upper_page, 1);
    do_read(32'h3F0, 1, "R10");
    chk(upper_page == 1'b1, "R9", "page restored", upper_page, 1);
    cfg_write(32'h0000_0003);
    do_read(32'h100_0A44, 1, "R9");
    #1;
    chk(upper_page == 1'b0, "R9", "page restored low", upper_page, 0);
    do_read(32'h100_0A48, 0, "R2");

    // R3: two-bus mode halves the flash address
    cfg_write(32'h4000_00BB);
    do_read(32'h180_0AC0, 1, "R3");
    do_read(32'h180_0804, 0, "R3");

    // R4/R5/R6: sweep dummy counts, mode byte on/off, stalls, bus modes
    for (int d = 0; d < 8; d++) begin
      for (int m = 0; m < 2; m++) begin
        logic [31:0] c;
        c = 32'(d) << 8;
        c[7:0] = 8'h03 + 8'(d);
        c[23:16] = 8'h50 + 8'(d);
        c[25] = m[0];
        c[30] = (d >= 4);
        stall_en = m[0];
        cfg_write(c);
        do_read(32'h400 * 32'(d * 2 + m + 3) + 32'((d * 37) % 1021), 1, "R4");
      end
    end
    stall_en = 0;

    // R10: config write in the middle of a fill
    cfg_write(32'h03A0_02EB);
    fork
      do_read(32'h2200, 1, "R10");
      begin
        repeat (300) @(negedge clk);
        cfg_write(32'h03A0_02EB);
      end
    join
    do_read(32'h2204, 1, "R10");
    do_read(32'h2208, 0, "R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule